// File: doc/BRIEF.md
# PAE Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 52-bit physical address using the three-level physical-address-extension scheme of 32-bit legacy paging. A request carries the virtual address together with the current paging control-register value. The walker then reads one 64-bit table entry per level over a simple read port. Each read has a request handshake and a response handshake. When the walk ends it returns either the physical address or a fault code that names the level where the walk stopped.

The top table is small. It has only four entries, 32 bytes in all, so the control register locates it with a 27-bit base at 32-byte granularity. That base places the top table somewhere in the low 4 GiB of physical memory. The two lower tables are full 4 KiB pages of 512 entries each. They are reached through 40-bit frame numbers held in the entries, so they may sit anywhere in the 52-bit space. Only one walk is in flight at a time.

Top module: `pae_walker`

## Requirements
- R1: While reset (`rstN` low) is asserted, `reqReady` is 1 and both `memReqValid` and `resValid` are 0.
- R2: The first read of a walk uses the address {20 zero bits, cr3Base[31:5], VA[31:30], 3'b000}. Bits [4:0] of `cr3Base` have no effect on any read address.
- R3: The second read uses the address {E0[51:12], VA[29:21], 3'b000}, where E0 is the first entry returned.
- R4: The third read uses the address {E1[51:12], VA[20:12], 3'b000}, where E1 is the second entry returned. Entry bits [63:52] and [11:1] have no effect on any address or result.
- R5: When all three entries have bit 0 set, the result is `resPa` = {E2[51:12], VA[11:0]} with `resFault` = 0 and `resLevel` = 2.
- R6: If bit 0 (present) of the entry read at level L (0, 1 or 2) is clear, the walk stops with `resFault` = 1 and `resLevel` = L, and no further read is issued.
- R7: Reads are issued one per level, from the top level down. A read request is raised in the cycle after the walk request is accepted, or in the cycle after the previous non-final response. No read request is raised while a response is outstanding.
- R8: `reqReady` is 0 from the cycle after a request is accepted until the cycle after the result is accepted. Requests presented during that time are ignored. While `resReady` is low, `resValid`, `resPa`, `resFault` and `resLevel` hold steady. The result appears in the cycle after the final response.
- R9: While `memReqReady` is low, `memReqValid` stays high and `memReqAddr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cr3Base | input | 32 | Paging control value; bits [31:5] locate the top table |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVa | input | 32 | Virtual address to translate |
| memReqValid | output | 1 | Entry read request valid |
| memReqReady | input | 1 | Memory takes the read request |
| memReqAddr | output | 52 | Byte address of the 64-bit entry |
| memRspValid | input | 1 | Entry data valid |
| memRspData | input | 64 | Entry data |
| resValid | output | 1 | Result valid |
| resReady | input | 1 | Consumer takes the result |
| resFault | output | 1 | Walk stopped on a non-present entry |
| resLevel | output | 2 | Level of the fault; 2 on success |
| resPa | output | 52 | Translated physical address (0 on fault) |

## Verification
Every output of this block is due at a fixed number of cycles after the handshake that causes it. A read request is due one cycle after a request is accepted or after a non-final response. The result is due one cycle after the final response. `reqReady` comes back one cycle after the result is taken. The bench model keeps a flag for each of these outputs and advances the flags at exactly those handshakes. At every falling edge it compares `reqReady`, `memReqValid` and `resValid` with the flags. It also compares each read address with the predicted address for that level and each held result with the predicted translation. Because the memory latency and both ready inputs vary from cycle to cycle, each timing rule is exercised under stalls as well as back-to-back handshakes.

// File: rtl/pae_walker_pkg.sv
package pae_walker_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 52;
  localparam int ENT_W     = 64;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 9;
  localparam int LOW_LVLS  = 2;
  localparam int TOP_IDX_W = VA_W - OFF_W - LOW_LVLS * IDX_W;
  localparam int ENT_B     = $clog2(ENT_W / 8);
  localparam int TOP_ALIGN = TOP_IDX_W + ENT_B;
  localparam int FRAME_W   = PA_W - OFF_W;
  localparam int LEVELS    = LOW_LVLS + 1;
  localparam int LVL_W     = $clog2(LEVELS);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} walkState_t;

  typedef struct packed {
    logic latchReq;
    logic latchNext;
    logic latchLeaf;
    logic latchFault;
  } walkStrobe_t;
endpackage

// File: rtl/pae_walker_ctrl.sv
module pae_walker_ctrl
  import pae_walker_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic             entryPresent,
  input  logic             resReady,
  output logic             reqReady,
  output logic             memReqValid,
  output logic             resValid,
  output logic [LVL_W-1:0] level,
  output walkStrobe_t      strobe
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walkState_t       state, stateNext;
  logic [LVL_W-1:0] levelNext;
  logic             rspTaken;
  logic             lastLevel;

  assign rspTaken  = (state == ST_WAIT) && memRspValid;
  assign lastLevel = (level == LAST_LVL);

  always_comb begin
    strobe.latchReq   = (state == ST_IDLE) && reqValid;
    strobe.latchNext  = rspTaken && entryPresent && !lastLevel;
    strobe.latchLeaf  = rspTaken && entryPresent && lastLevel;
    strobe.latchFault = rspTaken && !entryPresent;
  end

  always_comb begin
    stateNext = state;
    levelNext = level;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        stateNext = ST_ISSUE;
        levelNext = '0;
      end
      ST_ISSUE: if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (rspTaken) begin
        if (!entryPresent || lastLevel) begin
          stateNext = ST_DONE;
        end else begin
          stateNext = ST_ISSUE;
          levelNext = level + LVL_W'(1);
        end
      end
      ST_DONE: if (resReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      level <= '0;
    end else begin
      state <= stateNext;
      level <= levelNext;
    end
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);
  assign resValid    = (state == ST_DONE);

  // R8: the three handshake phases never overlap
  assert_one_phase_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqReady, memReqValid, resValid}));

  // R9: a stalled read request keeps its level
  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(level));

  // R7: after a read is taken, no new read until a response
  assert_wait_rsp_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid);

  // R7: a present non-final entry leads to the next level's read
  assert_level_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchNext |=> memReqValid && (level == $past(level) + LVL_W'(1)));

  // R8: an unaccepted result stays offered
  assert_res_wait_R8: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> resValid);
endmodule

// File: rtl/pae_walker_dp.sv
module pae_walker_dp
  import pae_walker_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [VA_W-1:0]  cr3Base,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [ENT_W-1:0] rspData,
  input  logic [LVL_W-1:0] level,
  input  walkStrobe_t      strobe,
  output logic             entryPresent,
  output logic [PA_W-1:0]  memReqAddr,
  output logic [PA_W-1:0]  resPa,
  output logic             resFault,
  output logic [LVL_W-1:0] resLevel
);
  logic [VA_W-1:0]         vaQ;
  logic [VA_W-TOP_ALIGN-1:0] topBaseQ;
  logic [FRAME_W-1:0]      nextBaseQ;
  logic [IDX_W-1:0]        lowIdx [LOW_LVLS];
  logic [IDX_W-1:0]        selIdx;
  logic [PA_W-1:0]         topAddr;
  logic [PA_W-1:0]         lowAddr;
  logic                    unusedBits;

  for (genvar g = 0; g < LOW_LVLS; g++) begin : gIdx
    assign lowIdx[g] = vaQ[VA_W-TOP_IDX_W-1-g*IDX_W -: IDX_W];
  end

  always_comb begin
    selIdx = '0;
    for (int k = 0; k < LOW_LVLS; k++) begin
      if (level == LVL_W'(k + 1)) selIdx = lowIdx[k];
    end
  end

  assign topAddr    = {{(PA_W-VA_W){1'b0}}, topBaseQ, vaQ[VA_W-1 -: TOP_IDX_W], {ENT_B{1'b0}}};
  assign lowAddr    = {nextBaseQ, selIdx, {ENT_B{1'b0}}};
  assign memReqAddr = (level == '0) ? topAddr : lowAddr;

  assign entryPresent = rspData[0];
  assign unusedBits   = ^{cr3Base[TOP_ALIGN-1:0], rspData[ENT_W-1:PA_W], rspData[OFF_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ       <= '0;
      topBaseQ  <= '0;
      nextBaseQ <= '0;
      resPa     <= '0;
      resFault  <= 1'b0;
      resLevel  <= '0;
    end else begin
      if (strobe.latchReq) begin
        vaQ      <= reqVa;
        topBaseQ <= cr3Base[VA_W-1:TOP_ALIGN];
      end
      if (strobe.latchNext) nextBaseQ <= rspData[PA_W-1:OFF_W];
      if (strobe.latchLeaf) begin
        resPa    <= {rspData[PA_W-1:OFF_W], vaQ[OFF_W-1:0]};
        resFault <= 1'b0;
        resLevel <= level;
      end
      if (strobe.latchFault) begin
        resPa    <= '0;
        resFault <= 1'b1;
        resLevel <= level;
      end
    end
  end

  // R6: a non-present entry yields a fault tagged with its level
  assert_fault_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchFault |=> resFault && (resLevel == $past(level)));

  // R5: a present leaf yields a clean result
  assert_leaf_ok_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchLeaf |=> !resFault && (resLevel == LVL_W'(LEVELS - 1)));
endmodule

// File: rtl/pae_walker.sv
module pae_walker
  import pae_walker_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      cr3Base,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [31:0]      reqVa,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [51:0]      memReqAddr,
  input  logic             memRspValid,
  input  logic [63:0]      memRspData,
  output logic             resValid,
  input  logic             resReady,
  output logic             resFault,
  output logic [1:0]       resLevel,
  output logic [51:0]      resPa
);
  walkStrobe_t      strobe;
  logic [LVL_W-1:0] level;
  logic             entryPresent;

  pae_walker_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .entryPresent (entryPresent),
    .resReady     (resReady),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .resValid     (resValid),
    .level        (level),
    .strobe       (strobe)
  );

  pae_walker_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cr3Base      (cr3Base),
    .reqVa        (reqVa),
    .rspData      (memRspData),
    .level        (level),
    .strobe       (strobe),
    .entryPresent (entryPresent),
    .memReqAddr   (memReqAddr),
    .resPa        (resPa),
    .resFault     (resFault),
    .resLevel     (resLevel)
  );

  // R9: a stalled read keeps its address
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));

  // R8: an unaccepted result keeps its contents
  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> resValid && $stable(resPa) && $stable(resFault) && $stable(resLevel));
endmodule

// File: tb/pae_walker_bench.sv
module pae_walker_bench;
  localparam int NJOBS = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cr3Base = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVa = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [51:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        resValid;
  logic        resReady = 1'b0;
  logic        resFault;
  logic [1:0]  resLevel;
  logic [51:0] resPa;

  always #5 clk = ~clk;

  pae_walker u_pae_walker (
    .clk(clk), .rstN(rstN), .cr3Base(cr3Base), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .resValid(resValid), .resReady(resReady),
    .resFault(resFault), .resLevel(resLevel), .resPa(resPa)
  );

  int totalChecks = 0;
  int badChecks = 0;
  bit finished = 1'b0;

  logic [63:0] mem [logic [63:0]];
  logic [31:0] jobCr3 [NJOBS];
  logic [31:0] jobVa  [NJOBS];
  int          nextJob = 0;

  // reference model state
  bit          busy = 1'b0;
  bit          expIssue = 1'b0;
  bit          expRes = 1'b0;
  logic [63:0] expAddr [$];
  int          readNo = 0;
  logic [63:0] expPa;
  bit          expFault;
  int          expLvl;
  bit          pend = 1'b0;
  int          pendCnt = 0;
  logic [63:0] pendData;
  bit          pendFinal;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    totalChecks++;
    if (!ok) begin
      badChecks++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  task automatic runModel(input logic [31:0] cr3, input logic [31:0] va);
    logic [63:0] tbl;
    logic [63:0] a;
    logic [63:0] e;
    int idx;
    expAddr.delete();
    readNo = 0;
    tbl = {32'd0, cr3 & 32'hFFFF_FFE0};
    for (int lv = 0; lv < 3; lv++) begin
      case (lv)
        0: idx = int'((va >> 30) & 32'd3);
        1: idx = int'((va >> 21) & 32'd511);
        default: idx = int'((va >> 12) & 32'd511);
      endcase
      a = tbl + 64'(idx) * 64'd8;
      expAddr.push_back(a);
      e = rd(a);
      if (!e[0]) begin
        expFault = 1'b1;
        expLvl = lv;
        expPa = 64'd0;
        return;
      end
      tbl = e & 64'h000F_FFFF_FFFF_F000;
    end
    expFault = 1'b0;
    expLvl = 2;
    expPa = tbl | {52'd0, va[11:0]};
  endtask

  task automatic setupMem();
    logic [63:0] junk;
    logic [63:0] t1;
    logic [63:0] t2;
    logic [63:0] frame;
    logic [63:0] a;
    int sel;
    junk = 64'hABC0_0000_0000_0F5E;
    for (int i = 0; i < NJOBS; i++) begin
      jobCr3[i] = 32'h0040_0000 + 32'(i) * 32'd64 + 32'((i * 7) % 32);
      if (i == NJOBS - 1) jobCr3[i] = 32'hFFFF_FFC5;
      if (i == 0) jobVa[i] = 32'h0;
      else if (i == 1 || i == NJOBS - 1) jobVa[i] = 32'hFFFF_FFFF;
      else jobVa[i] = $urandom;
      sel = i % 6;
      t1 = ((i % 2) == 1 ? 64'h000F_A000_0000_0000 : 64'h0000_0001_0000_0000) + 64'(i) * 64'h2000;
      t2 = t1 + 64'h1000;
      frame = {$urandom, $urandom} & 64'h0000_00FF_FFFF_FFFF;
      if (i == NJOBS - 1) frame = 64'h0000_00FF_FFFF_FFFF;
      a = {32'd0, jobCr3[i] & 32'hFFFF_FFE0} + 64'(jobVa[i] >> 30) * 64'd8;
      mem[a] = t1 | junk | ((sel == 0) ? 64'd0 : 64'd1);
      a = t1 + 64'((jobVa[i] >> 21) & 32'd511) * 64'd8;
      mem[a] = t2 | junk | ((sel == 1) ? 64'd0 : 64'd1);
      a = t2 + 64'((jobVa[i] >> 12) & 32'd511) * 64'd8;
      mem[a] = (frame << 12) | junk | ((sel == 2) ? 64'd0 : 64'd1);
    end
  endtask

  task automatic step();
    bit wasBusy;
    string tag;
    wasBusy = busy;
    // cycle-exact comparisons
    chk(reqReady == !busy, "R8", "reqReady", 64'(reqReady), 64'(!busy));
    chk(memReqValid == expIssue, "R7", "memReqValid", 64'(memReqValid), 64'(expIssue));
    chk(resValid == expRes, "R8", "resValid timing", 64'(resValid), 64'(expRes));
    if (memReqValid) begin
      case (readNo)
        0: tag = "R2";
        1: tag = "R3";
        default: tag = "R4";
      endcase
      if (expAddr.size() == 0)
        chk(1'b0, "R6", "unexpected read", {12'd0, memReqAddr}, 64'd0);
      else
        chk({12'd0, memReqAddr} == expAddr[0], tag, "read address", {12'd0, memReqAddr}, expAddr[0]);
    end
    if (resValid && expRes) begin
      chk(resFault == expFault, expFault ? "R6" : "R5", "resFault", 64'(resFault), 64'(expFault));
      chk(int'(resLevel) == expLvl, expFault ? "R6" : "R5", "resLevel", 64'(resLevel), 64'(expLvl));
      chk({12'd0, resPa} == expPa, "R5", "resPa", {12'd0, resPa}, expPa);
    end
    // response channel
    memRspValid = 1'b0;
    if (pend) begin
      pendCnt--;
      if (pendCnt == 0) begin
        memRspValid = 1'b1;
        memRspData = pendData;
        pend = 1'b0;
        if (pendFinal) expRes = 1'b1;
        else expIssue = 1'b1;
      end
    end
    // request channel
    memReqReady = ($urandom % 3) != 0;
    if (memReqValid && memReqReady && expAddr.size() != 0) begin
      pendData = rd(expAddr[0]);
      void'(expAddr.pop_front());
      readNo++;
      pendFinal = (expAddr.size() == 0);
      pend = 1'b1;
      pendCnt = 1 + int'($urandom % 3);
      expIssue = 1'b0;
    end
    // result channel
    resReady = ($urandom % 2) != 0;
    if (resValid && resReady && expRes) begin
      chk(expAddr.size() == 0, "R6", "reads left at result", 64'(expAddr.size()), 64'd0);
      expRes = 1'b0;
      busy = 1'b0;
    end
    // new walk request; noise while busy must be ignored (R8)
    if (wasBusy) begin
      reqValid = ($urandom % 2) != 0;
      reqVa = $urandom;
      cr3Base = $urandom;
    end else if (nextJob < NJOBS) begin
      reqValid = 1'b1;
      reqVa = jobVa[nextJob];
      cr3Base = jobCr3[nextJob];
      runModel(jobCr3[nextJob], jobVa[nextJob]);
      nextJob++;
      busy = 1'b1;
      expIssue = 1'b1;
    end else begin
      reqValid = 1'b0;
    end
  endtask

  initial begin
    setupMem();
    repeat (3) begin
      @(negedge clk);
      chk(reqReady == 1'b1, "R1", "reset reqReady", 64'(reqReady), 64'd1);
      chk(memReqValid == 1'b0, "R1", "reset memReqValid", 64'(memReqValid), 64'd0);
      chk(resValid == 1'b0, "R1", "reset resValid", 64'(resValid), 64'd0);
    end
    rstN = 1'b1;
    while (nextJob < NJOBS || busy) begin
      @(negedge clk);
      step();
    end
    repeat (3) begin
      @(negedge clk);
      step();
    end
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      totalChecks++;
      badChecks++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
      $finish;
    end
  end
endmodule